// File: doc/BRIEF.md
# Serial ADC Conversion Result Reader

This block is a serial-peripheral master that fetches one conversion result from a 14-bit serial-output analog-to-digital converter. It uses clock polarity 0 and phase 0: the serial clock idles low, the block samples the converter's data line on each rising edge, and the converter moves to its next bit on each falling edge. One start request produces one frame. Chip select goes low, 24 serial clocks run as three back-to-back bytes, and chip select goes high again.

The incoming frame has three parts. The first byte should be all zeros. The next 14 bits carry the sample, most significant bit first. The last two bits are status flags. The block splits the frame into these fields. It presents the sample, the status and a framing-error flag together with a one-cycle completion strobe. The serial clock comes from the system clock through a divider. By default the divider is derived from the system clock frequency and the converter's 4.8 MHz maximum, so the serial clock never runs faster than the converter allows.

Top module: `spi_adc_reader`

## Requirements
- R1: Out of reset, and whenever no frame is in progress, cs_no is 1, sclk_o is 0, busy_o is 0 and done_o is 0.
- R2: A start_i pulse while idle drives cs_no low and busy_o high on the next clock. sclk_o first rises no sooner than HALF_DIV system clocks after cs_no falls.
- R3: Each frame contains exactly 24 rising edges of sclk_o, all within one low period of cs_no. sclk_o is never high while cs_no is high.
- R4: sclk_o stays high for HALF_DIV system clocks and low for at least HALF_DIV system clocks between edges. The default HALF_DIV = ceil(SYS_CLK_HZ / (2 * SCLK_MAX_HZ)) keeps the serial clock at or below SCLK_MAX_HZ (4.8 MHz).
- R5: miso_i is sampled at each rising edge of sclk_o, and the frame is assembled most significant bit first. Frame bits 9 to 22 (counting received bits from 1) become data_o[13] down to data_o[0].
- R6: Frame bit 23 becomes status_o[1] and frame bit 24 becomes status_o[0].
- R7: frame_err_o is 1 exactly when any of frame bits 1 to 8 is 1. It changes only together with done_o.
- R8: cs_no rises no sooner than HALF_DIV system clocks after the 24th rising edge. miso_i has no effect while cs_no is high.
- R9: done_o pulses for exactly one clock, on the clock where cs_no rises. data_o, status_o and frame_err_o take their new values in that same clock, and busy_o is 0 there.
- R10: A start_i request while busy_o is 1 is ignored. The frame in progress completes unchanged, and no second frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one conversion read |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle completion strobe |
| data_o | output | 14 | Received sample |
| status_o | output | 2 | Received trailing status bits |
| frame_err_o | output | 1 | Leading byte was not all zeros |
| cs_no | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Serial clock to converter |
| miso_i | input | 1 | Serial data from converter |

## Verification
The bench builds two copies of the block. The first uses the default 125 MHz / 4.8 MHz parameters, which yield a divider of 14. With it, the real setup, hold and half-period spacing can be measured against the limit, and it runs the full vector table, including frames whose leading byte is corrupted. The second uses a divider of 1. This is the tightest case, where every system clock produces a serial clock edge, and it shows that the bit alignment still holds when no idle cycles separate sampling from shifting. A model of the converter drives the data line high whenever chip select is high, so any sample taken outside the frame would corrupt an all-zero result.

// File: rtl/spi_adc_pkg.sv
package spi_adc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_HOLD
  } rd_state_e;

  function automatic int half_div_for(input int sys_hz, input int max_hz);
    return (sys_hz + 2 * max_hz - 1) / (2 * max_hz);
  endfunction
endpackage

// File: rtl/spi_adc_tick.sv
module spi_adc_tick #(
  parameter int HALF_DIV = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i)          cnt_q <= '0;
    else if (cnt_q == LAST)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/spi_adc_shift.sv
module spi_adc_shift #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    q_o[i] <= 1'b0;
        else if (clr_i) q_o[i] <= 1'b0;
        else if (en_i)  q_o[i] <= bit_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    q_o[i] <= 1'b0;
        else if (clr_i) q_o[i] <= 1'b0;
        else if (en_i)  q_o[i] <= q_o[i-1];
      end
    end
  end
endmodule

// File: rtl/spi_adc_ctrl.sv
module spi_adc_ctrl
  import spi_adc_pkg::*;
#(
  parameter int FRAME_BITS = 24,
  parameter int HALF_DIV   = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  output logic run_o,
  output logic busy_o,
  output logic cs_no,
  output logic sclk_o,
  output logic sample_o,
  output logic clear_o,
  output logic finish_o
);
  localparam int BW = $clog2(FRAME_BITS + 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS);

  rd_state_e     st_q;
  logic [BW-1:0] bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cs_no  <= 1'b1;
      sclk_o <= 1'b0;
      bit_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_SETUP;
          cs_no <= 1'b0;
          bit_q <= '0;
        end
        ST_SETUP: if (tick_i) begin
          st_q   <= ST_SHIFT;
          sclk_o <= 1'b1;
          bit_q  <= BW'(1);
        end
        ST_SHIFT: if (tick_i) begin
          if (sclk_o) begin
            sclk_o <= 1'b0;
            if (bit_q == LAST_BIT) st_q <= ST_HOLD;
          end else begin
            sclk_o <= 1'b1;
            bit_q  <= bit_q + 1'b1;
          end
        end
        ST_HOLD: if (tick_i) begin
          st_q  <= ST_IDLE;
          cs_no <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign run_o    = (st_q != ST_IDLE);
  assign busy_o   = run_o;
  assign clear_o  = (st_q == ST_IDLE) && start_i;
  assign sample_o = tick_i && ((st_q == ST_SETUP) || (st_q == ST_SHIFT && !sclk_o));
  assign finish_o = tick_i && (st_q == ST_HOLD);

  // independent run-length monitor of the serial clock
  localparam int LW = $clog2(HALF_DIV + 1) + 1;
  logic          sclk_seen_q;
  logic [LW-1:0] run_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_seen_q <= 1'b0;
      run_len_q   <= '0;
    end else begin
      sclk_seen_q <= sclk_o;
      if (sclk_o != sclk_seen_q)          run_len_q <= LW'(1);
      else if (run_len_q < LW'(HALF_DIV)) run_len_q <= run_len_q + 1'b1;
    end
  end

  AST_IDLE_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cs_no && !sclk_o)); // R1
  AST_SCLK_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_no); // R3
  AST_BIT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_q <= LAST_BIT); // R3
  AST_SCLK_HALF_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o != sclk_seen_q) |-> (run_len_q >= LW'(HALF_DIV))); // R4
  AST_CS_FALL_FROM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> $past(!busy_o)); // R10
endmodule

// File: rtl/spi_adc_reader.sv
module spi_adc_reader
  import spi_adc_pkg::*;
#(
  parameter int SYS_CLK_HZ  = 125_000_000,
  parameter int SCLK_MAX_HZ = 4_800_000,
  parameter int HALF_DIV    = half_div_for(SYS_CLK_HZ, SCLK_MAX_HZ),
  parameter int LEAD_W      = 8,
  parameter int DATA_W      = 14,
  parameter int STAT_W      = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic [STAT_W-1:0] status_o,
  output logic              frame_err_o,
  output logic              cs_no,
  output logic              sclk_o,
  input  logic              miso_i
);
  localparam int FRAME_BITS = LEAD_W + DATA_W + STAT_W;

  logic                  run, tick, sample, clear, finish;
  logic [FRAME_BITS-1:0] frame;

  spi_adc_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .tick_o(tick)
  );

  spi_adc_ctrl #(.FRAME_BITS(FRAME_BITS), .HALF_DIV(HALF_DIV)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .tick_i  (tick),
    .run_o   (run),
    .busy_o  (busy_o),
    .cs_no   (cs_no),
    .sclk_o  (sclk_o),
    .sample_o(sample),
    .clear_o (clear),
    .finish_o(finish)
  );

  spi_adc_shift #(.W(FRAME_BITS)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clear),
    .en_i  (sample),
    .bit_i (miso_i),
    .q_o   (frame)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      data_o      <= '0;
      status_o    <= '0;
      frame_err_o <= 1'b0;
    end else begin
      done_o <= finish;
      if (finish) begin
        data_o      <= frame[STAT_W +: DATA_W];
        status_o    <= frame[STAT_W-1:0];
        frame_err_o <= |frame[FRAME_BITS-1 -: LEAD_W];
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_WITH_CS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($rose(cs_no) && !busy_o)); // R9
  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(frame_err_o)); // R7
endmodule

// File: tb/sim_spi_adc_reader.sv
module adc_frame_model (
  input  logic        cs_n,
  input  logic        sclk,
  input  logic [23:0] word,
  output logic        miso
);
  int idx = 23;
  always @(negedge cs_n) idx = 23;
  always @(negedge sclk) if (!cs_n && idx > 0) idx = idx - 1;
  // drive 1 while deselected: stands in for a floating line
  assign miso = cs_n ? 1'b1 : word[idx];
endmodule

module sim_spi_adc_reader;
  localparam int HALF0 = 14;
  localparam int NV = 8;
  localparam logic [23:0] FRAMES [NV] = '{
    24'h000000, 24'h00FFFF, 24'h00AAAA, 24'h005555,
    24'h008001, 24'h000002, 24'h801234, 24'h01FFFC
  };
  // {frame_err, data[13:0], status[1:0]}
  localparam logic [16:0] EXPECT [NV] = '{
    {1'b0, 14'h0000, 2'd0}, {1'b0, 14'h3FFF, 2'd3},
    {1'b0, 14'h2AAA, 2'd2}, {1'b0, 14'h1555, 2'd1},
    {1'b0, 14'h2000, 2'd1}, {1'b0, 14'h0000, 2'd2},
    {1'b1, 14'h048D, 2'd0}, {1'b1, 14'h3FFF, 2'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        start0 = 1'b0, start1 = 1'b0;
  logic [23:0] word0 = '0, word1 = '0;
  logic        busy0, done0, err0, cs0, sclk0, miso0;
  logic        busy1, done1, err1, cs1, sclk1, miso1;
  logic [13:0] data0, data1;
  logic [1:0]  stat0, stat1;

  spi_adc_reader u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start0), .busy_o(busy0), .done_o(done0),
    .data_o(data0), .status_o(stat0), .frame_err_o(err0), .cs_no(cs0),
    .sclk_o(sclk0), .miso_i(miso0)
  );
  adc_frame_model m0 (.cs_n(cs0), .sclk(sclk0), .word(word0), .miso(miso0));

  spi_adc_reader #(.HALF_DIV(1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start1), .busy_o(busy1), .done_o(done1),
    .data_o(data1), .status_o(stat1), .frame_err_o(err1), .cs_no(cs1),
    .sclk_o(sclk1), .miso_i(miso1)
  );
  adc_frame_model m1 (.cs_n(cs1), .sclk(sclk1), .word(word1), .miso(miso1));

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // serial-clock monitor for u0, sampled on the falling system clock edge
  int cyc = 0, rises = 0, cs_falls = 0, run_len = 0, min_run = 1000000;
  int t_cs_fall = 0, t_first = 0, t_last = 0, t_cs_rise = 0;
  logic p_sclk = 1'b0, p_cs = 1'b1;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (sclk0 != p_sclk) begin
        if (run_len < min_run && t_first != 0) min_run = run_len;
        run_len = 1;
      end else run_len++;
      if (p_cs && !cs0) begin rises = 0; t_cs_fall = cyc; cs_falls++; end
      if (sclk0 && !p_sclk) begin
        rises++;
        if (rises == 1) t_first = cyc;
        t_last = cyc;
      end
      if (cs0 && !p_cs) t_cs_rise = cyc;
      p_sclk = sclk0;
      p_cs = cs0;
    end
  end

  task automatic wait_done0(output int n);
    n = 0;
    while (!done0 && n < 2000) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    logic [16:0] e;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs0 == 1'b1, "R1 cs_n in reset", cs0, 1);
    chk(sclk0 == 1'b0, "R1 sclk in reset", sclk0, 0);
    chk(busy0 == 1'b0 && done0 == 1'b0, "R1 busy/done in reset", {busy0, done0}, 0);
    chk(data0 == '0, "R1 data in reset", data0, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(cs0 && !sclk0 && !busy0, "R1 idle after reset", {cs0, sclk0, busy0}, 4);

    for (int v = 0; v < NV; v++) begin
      word0 = FRAMES[v];
      e = EXPECT[v];
      min_run = 1000000;
      t_first = 0;
      @(negedge clk); start0 = 1'b1;
      @(negedge clk); start0 = 1'b0;
      chk(!cs0 && busy0, "R2 cs low and busy after start", {cs0, busy0}, 1);
      wait_done0(n);
      chk(n < 2000, "R9 done seen", n, 0);
      chk(data0 == e[15:2], "R5 data", data0, e[15:2]);
      chk(stat0 == e[1:0], "R6 status", stat0, e[1:0]);
      chk(err0 == e[16], "R7 frame error", err0, e[16]);
      chk(cs0 && !busy0, "R9 cs high, idle at done", {cs0, busy0}, 2);
      @(negedge clk);
      chk(!done0, "R9 done one cycle", done0, 0);
      chk(rises == 24, "R3 rising edges per frame", rises, 24);
      chk(t_first - t_cs_fall >= HALF0, "R2 setup cycles", t_first - t_cs_fall, HALF0);
      chk(t_cs_rise - t_last >= HALF0, "R8 hold cycles", t_cs_rise - t_last, HALF0);
      chk(min_run == HALF0 && 2 * min_run * 4_800_000 >= 125_000_000,
          "R4 sclk half period", min_run, HALF0);
      repeat (3) @(negedge clk);
    end

    // R8: miso high outside the frame must not leak into an all-zero result
    word0 = 24'h000000;
    @(negedge clk); start0 = 1'b1;
    @(negedge clk); start0 = 1'b0;
    wait_done0(n);
    chk(data0 == 0 && stat0 == 0 && !err0, "R8 miso ignored while deselected",
        {err0, data0, stat0}, 0);
    repeat (3) @(negedge clk);

    // R10: start while busy is ignored
    begin
      int falls_before;
      falls_before = cs_falls;
      word0 = 24'h003FFC;
      @(negedge clk); start0 = 1'b1;
      @(negedge clk); start0 = 1'b0;
      repeat (100) @(negedge clk);
      start0 = 1'b1;
      @(negedge clk); start0 = 1'b0;
      wait_done0(n);
      chk(data0 == 14'h0FFF && stat0 == 2'd0, "R10 frame unchanged by busy start",
          {data0, stat0}, {14'h0FFF, 2'd0});
      repeat (60) @(negedge clk);
      chk(!busy0 && cs0, "R10 no second frame", {busy0, cs0}, 1);
      chk(cs_falls - falls_before == 1, "R10 one cs assertion", cs_falls - falls_before, 1);
    end

    // divider of 1 on u1
    word1 = 24'h00A5F3;
    @(negedge clk); start1 = 1'b1;
    @(negedge clk); start1 = 1'b0;
    n = 0;
    while (!done1 && n < 500) begin @(negedge clk); n++; end
    chk(data1 == 14'h297C, "R5 data at divider 1", data1, 14'h297C);
    chk(stat1 == 2'd3, "R6 status at divider 1", stat1, 3);
    chk(!err1 && cs1, "R7 no error at divider 1", {err1, cs1}, 1);
    @(negedge clk);
    chk(!done1, "R9 done one cycle at divider 1", done1, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule